// File: doc/BRIEF.md
# Interrupt-on-Terminal-Count Timer Channel

This block is one 16-bit down-counting channel of an interval timer, fixed in its event-counting mode: the output stays low while a programmed count runs down and goes high when the count reaches zero. A host on the system clock writes a control byte and then one or two count bytes through a small write port. The counter side has a slow counter clock input, a gate input that enables counting, and the terminal-count output.

The counter clock and the gate are synchronised into the system clock domain. A counter clock pulse is a rise followed by a fall, and all loading and decrementing happen when the fall is detected. A newly written count sits in a holding register until the next pulse moves it into the counting element. That loading pulse does not count, so a count of N takes N+1 pulses to finish. When the count is written in two bytes, the first byte stops the channel at once and the second byte arms the load. Writing the count again while the channel runs restarts it from the new value.

Top module: `tct_timer_chan`

## Requirements
- R1: After reset, `out` is low. Counter clock pulses with no count written leave it low.
- R2: A write with `wr_ctrl`=1 forces `out` low within two system clocks, stops counting, cancels any pending load and resets the byte pointer to the low byte. Bit 0 of the written byte selects the access form: 0 means low byte only, with the high byte taken as zero, and 1 means low byte then high byte.
- R3: With `gate` high, a count N written as a count byte (`wr_ctrl`=0) is loaded by the first falling `cnt_clk` edge that follows a rise, and that edge does not decrement. `out` goes high at the fall of pulse N+1, and a rising edge alone never changes `out`.
- R4: While `gate` is low the count holds. Changing `gate` never changes `out` directly.
- R5: A count written while `gate` is low is still loaded by the next pulse. Once `gate` goes high, `out` rises after N pulses with no extra load pulse.
- R6: A count written while a count is running is loaded by the next pulse, and counting continues from the new value.
- R7: In two-byte access, writing the low byte forces `out` low and stops counting at once, with no counter clock pulse needed.
- R8: In two-byte access, writing the high byte forms the count high*256+low, and the next pulse loads it.
- R9: After terminal count the counter keeps decrementing and wraps through 0xFFFF, and `out` stays high until the next write. A loaded count of 0 behaves as 65536 and does not raise `out` early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one system clock per byte |
| wr_ctrl | input | 1 | 1: the byte is a control byte; 0: the byte is a count byte |
| wr_data | input | 8 | Written byte |
| cnt_clk | input | 1 | Counter clock, much slower than clk |
| gate | input | 1 | Count enable, sampled together with cnt_clk |
| out | output | 1 | Terminal-count output, registered |

## Verification
The hardest state to reach is a two-byte count left half written: the channel must stay frozen with `out` low through several counter clock pulses, and only then receive its high byte. The stimulus first runs a two-byte count to terminal count so that `out` is high, then writes only the low byte and checks that `out` drops before any pulse. It then pulses the counter clock several times and checks that nothing moves. Finally it writes the high byte and checks the exact pulse at which `out` rises for the 258 count. A behavioural reference model, advanced at each counter clock fall and at each write, is compared with `out` on every system clock once the synchroniser latency has passed.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic {
    ACC_LO   = 1'b0,
    ACC_LOHI = 1'b1
  } acc_e;
endpackage

// File: rtl/tct_sync_edge.sv
module tct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cnt_clk,
  input  logic gate,
  output logic tick,
  output logic gate_s
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] c_sh, g_sh;
  logic c_prev, rise_seen;
  logic rise_c, fall_c;

  assign rise_c = c_sh[MSB] & ~c_prev;
  assign fall_c = ~c_sh[MSB] & c_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_sh      <= '0;
      g_sh      <= '0;
      c_prev    <= 1'b0;
      rise_seen <= 1'b0;
      tick      <= 1'b0;
      gate_s    <= 1'b0;
    end else begin
      c_sh   <= {c_sh[MSB-1:0], cnt_clk};
      g_sh   <= {g_sh[MSB-1:0], gate};
      c_prev <= c_sh[MSB];
      if (rise_c)      rise_seen <= 1'b1;
      else if (fall_c) rise_seen <= 1'b0;
      tick   <= fall_c & rise_seen;
      gate_s <= g_sh[MSB];
    end
  end

  AST_TICK_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    tick |-> !c_prev); // R3
endmodule

// File: rtl/tct_host_if.sv
module tct_host_if
  import tct_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_ctrl,
  input  logic [DW-1:0]   wr_data,
  output logic [2*DW-1:0] cr_q,
  output logic            ev_ctrl,
  output logic            ev_drop,
  output logic            ev_stop,
  output logic            ev_arm
);
  localparam int CW = 2 * DW;

  acc_e acc_q;
  logic hi_next_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q      <= '0;
      acc_q     <= ACC_LO;
      hi_next_q <= 1'b0;
      ev_ctrl   <= 1'b0;
      ev_drop   <= 1'b0;
      ev_stop   <= 1'b0;
      ev_arm    <= 1'b0;
    end else begin
      ev_ctrl <= 1'b0;
      ev_drop <= 1'b0;
      ev_stop <= 1'b0;
      ev_arm  <= 1'b0;
      if (wr_en) begin
        if (wr_ctrl) begin
          acc_q     <= acc_e'(wr_data[0]);
          hi_next_q <= 1'b0;
          ev_ctrl   <= 1'b1;
        end else if (acc_q == ACC_LO) begin
          cr_q    <= {{DW{1'b0}}, wr_data};
          ev_drop <= 1'b1;
          ev_arm  <= 1'b1;
        end else if (!hi_next_q) begin
          cr_q[DW-1:0] <= wr_data;
          ev_drop      <= 1'b1;
          ev_stop      <= 1'b1;
          hi_next_q    <= 1'b1;
        end else begin
          cr_q[CW-1:DW] <= wr_data;
          ev_arm        <= 1'b1;
          hi_next_q     <= 1'b0;
        end
      end
    end
  end

  AST_CTRL_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ev_ctrl |-> !hi_next_q); // R2
  AST_ARM_NOT_STOP: assert property (@(posedge clk) disable iff (rst)
    !(ev_arm && ev_stop)); // R8
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate_s,
  input  logic [CW-1:0] cr,
  input  logic          ev_ctrl,
  input  logic          ev_drop,
  input  logic          ev_stop,
  input  logic          ev_arm,
  output logic          out
);
  logic [CW-1:0] ce_q;
  logic armed_q, run_q, out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q    <= '0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      if (tick) begin
        if (armed_q) begin
          ce_q    <= cr;
          run_q   <= 1'b1;
          armed_q <= 1'b0;
        end else if (run_q && gate_s) begin
          ce_q <= ce_q - CW'(1);
          if (ce_q == CW'(1)) out_q <= 1'b1;
        end
      end
      if (ev_ctrl || ev_stop) begin
        run_q   <= 1'b0;
        armed_q <= 1'b0;
        out_q   <= 1'b0;
      end
      if (ev_drop) out_q   <= 1'b0;
      if (ev_arm)  armed_q <= 1'b1;
    end
  end

  assign out = out_q;

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> $past(tick)); // R3
  AST_CTRL_LOW: assert property (@(posedge clk) disable iff (rst)
    ev_ctrl |=> !out_q); // R2
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> !out_q); // R7
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick && !armed_q && !gate_s) |=> $stable(ce_q)); // R4
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (tick && armed_q) |=> (ce_q == $past(cr))); // R6
  AST_OUT_STAYS: assert property (@(posedge clk) disable iff (rst)
    (out_q && !ev_ctrl && !ev_drop && !ev_stop) |=> out_q); // R9
endmodule

// File: rtl/tct_timer_chan.sv
module tct_timer_chan #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wr_data,
  input  logic          cnt_clk,
  input  logic          gate,
  output logic          out
);
  localparam int CW = 2 * DW;

  logic          tick, gate_s;
  logic [CW-1:0] cr;
  logic          ev_ctrl, ev_drop, ev_stop, ev_arm;

  tct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cnt_clk(cnt_clk), .gate(gate),
    .tick(tick), .gate_s(gate_s)
  );

  tct_host_if #(.DW(DW)) u_host (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .cr_q(cr), .ev_ctrl(ev_ctrl), .ev_drop(ev_drop), .ev_stop(ev_stop),
    .ev_arm(ev_arm)
  );

  tct_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .gate_s(gate_s), .cr(cr),
    .ev_ctrl(ev_ctrl), .ev_drop(ev_drop), .ev_stop(ev_stop), .ev_arm(ev_arm),
    .out(out)
  );
endmodule

// File: tb/test_tct_timer_chan.sv
module test_tct_timer_chan;
  localparam int HALF   = 10;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_ctrl = 1'b0;
  logic [7:0] wr_data = '0;
  logic cnt_clk = 1'b0, gate = 1'b0;
  logic out;

  int vectors = 0, miscompares = 0, settle = SETTLE;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  logic [15:0] m_cr = '0, m_ce = '0;
  bit m_out = 0, m_run = 0, m_armed = 0, m_two = 0, m_hi = 0;

  always #2 clk = ~clk;

  tct_timer_chan i_tct_timer_chan (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .cnt_clk(cnt_clk), .gate(gate), .out(out)
  );

  task automatic m_fall();
    if (m_armed) begin
      m_ce = m_cr; m_armed = 0; m_run = 1;
    end else if (m_run && gate) begin
      if (m_ce == 16'd1) m_out = 1;
      m_ce = m_ce - 16'd1;
    end
  endtask

  task automatic m_write(bit c, logic [7:0] d);
    if (c) begin
      m_out = 0; m_run = 0; m_armed = 0; m_two = d[0]; m_hi = 0;
    end else if (!m_two) begin
      m_cr = {8'h00, d}; m_out = 0; m_armed = 1;
    end else if (!m_hi) begin
      m_cr[7:0] = d; m_out = 0; m_run = 0; m_armed = 0; m_hi = 1;
    end else begin
      m_cr[15:8] = d; m_armed = 1; m_hi = 0;
    end
  endtask

  // per-clock comparison against the model, after synchroniser latency
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (settle > 0) settle--;
      else begin
        vectors++;
        if (out !== m_out) begin
          miscompares++;
          $display("FAIL %s model compare: out=%0b expected=%0b at %0t",
                   cur_req, out, m_out, $time);
        end
      end
    end
  end

  task automatic chk(string req, logic exp);
    vectors++;
    if (out !== exp) begin
      miscompares++;
      $display("FAIL %s check: out=%0b expected=%0b at %0t", req, out, exp, $time);
    end
  endtask

  task automatic host_wr(bit c, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ctrl = c; wr_data = d;
    m_write(c, d);
    settle = SETTLE;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (SETTLE + 2) @(negedge clk);
  endtask

  task automatic set_gate(logic g);
    @(negedge clk);
    gate = g;
    settle = SETTLE;
    repeat (SETTLE + 2) @(negedge clk);
  endtask

  task automatic cnt_rise();
    @(negedge clk);
    cnt_clk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cnt_fall();
    @(negedge clk);
    cnt_clk = 1'b0;
    m_fall();
    settle = SETTLE;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      cnt_rise();
      cnt_fall();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle = SETTLE;
    repeat (4) @(negedge clk);

    // R1: reset state, and pulses without a count
    cur_req = "R1";
    chk("R1", 1'b0);
    pulses(3);
    chk("R1", 1'b0);

    // R3: one-byte count of 5, gate high
    cur_req = "R3";
    host_wr(1'b1, 8'h00);
    set_gate(1'b1);
    host_wr(1'b0, 8'd5);
    for (int i = 0; i < 5; i++) begin
      pulses(1);
      chk("R3", 1'b0);
    end
    cnt_rise();
    chk("R3", 1'b0);
    cnt_fall();
    chk("R3", 1'b1);

    // R9: keeps counting past terminal count, out stays high
    cur_req = "R9";
    pulses(3);
    chk("R9", 1'b1);

    // R4: gate has no effect on a high out
    cur_req = "R4";
    set_gate(1'b0);
    chk("R4", 1'b1);
    set_gate(1'b1);
    chk("R4", 1'b1);

    // R2: control write drops out without a pulse
    cur_req = "R2";
    host_wr(1'b1, 8'h00);
    chk("R2", 1'b0);
    pulses(2);
    chk("R2", 1'b0);

    // R5: count written with gate low
    cur_req = "R5";
    set_gate(1'b0);
    host_wr(1'b0, 8'd3);
    pulses(4);
    chk("R5", 1'b0);
    set_gate(1'b1);
    pulses(2);
    chk("R5", 1'b0);
    pulses(1);
    chk("R5", 1'b1);

    // R4: gate low mid-count holds the count
    cur_req = "R4";
    host_wr(1'b0, 8'd3);
    pulses(2);
    set_gate(1'b0);
    pulses(4);
    chk("R4", 1'b0);
    set_gate(1'b1);
    pulses(1);
    chk("R4", 1'b0);
    pulses(1);
    chk("R4", 1'b1);

    // R6: rewrite while running
    cur_req = "R6";
    host_wr(1'b0, 8'd10);
    pulses(3);
    host_wr(1'b0, 8'd4);
    pulses(4);
    chk("R6", 1'b0);
    pulses(1);
    chk("R6", 1'b1);

    // R7 / R8: two-byte access
    cur_req = "R8";
    host_wr(1'b1, 8'h01);
    host_wr(1'b0, 8'h03);
    host_wr(1'b0, 8'h00);
    pulses(4);
    chk("R8", 1'b1);
    cur_req = "R7";
    host_wr(1'b0, 8'h02);
    chk("R7", 1'b0);
    pulses(5);
    chk("R7", 1'b0);
    cur_req = "R8";
    host_wr(1'b0, 8'h01);
    pulses(258);
    chk("R8", 1'b0);
    pulses(1);
    chk("R8", 1'b1);

    // R9: count of zero is 65536, no early rise
    cur_req = "R9";
    host_wr(1'b1, 8'h00);
    host_wr(1'b0, 8'h00);
    pulses(300);
    chk("R9", 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule